// File: doc/BRIEF.md
# DMA Word Count and Address Counter

This block keeps the two running counters of a block-transfer DMA channel: a word count that software preloads with the negative of the transfer length, and an 18-bit memory address. The low 16 address bits sit in an address register; the top two bits sit in a small extension field that belongs to a neighbouring control word. Every 36-bit word moved is signalled by one strobe, and on that strobe both counters move by two.

Software reaches the counters through a 16-bit register write port with two byte enables and a 2-bit register select. A ready input marks the channel as idle. Some fields can only be changed while it is high. A direction input picks whether the address climbs or falls. An inhibit bit holds the address still so that a single location can be streamed. Three clear inputs reset the address side. The transfer engine outside uses the count-zero output to end a transfer.

Top module: `dma_xfer_counter`

## Requirements
- R1: Select code 0 writes the word count; byte enable bit 0 updates count bits 7:0 and bit 1 updates bits 15:8, independent of ready.
- R2: Each transfer strobe adds 2 to the word count, wrapping modulo 2^16; a count write in the same cycle takes precedence over the step.
- R3: The count-zero output is 1 exactly when the word count is 0, so a count loaded with the two's complement of 2N reaches zero after N strobes.
- R4: Select code 1 writes address bits 15:0 by byte lane (enable bit 0 for bits 7:0, bit 1 for bits 15:8); address bit 0 ignores writes and reads 0.
- R5: With reverse low and inhibit clear, a strobe adds 2 to the full 18-bit address, carrying into bits 17:16 and wrapping from 0x3FFFE to 0.
- R6: With reverse high and inhibit clear, a strobe subtracts 2 from the 18-bit address, borrowing from bits 17:16 and wrapping from 0 to 0x3FFFE.
- R7: While the inhibit bit is set, strobes leave the address unchanged; the count still steps.
- R8: The extension field (select code 2, data bits 9:8, byte enable bit 1) and the inhibit bit (select code 3, data bit 3, byte enable bit 0) accept writes only while ready is 1; writes with ready 0 are ignored.
- R9: Bridge clear or controller clear zeroes the address, the extension field and the inhibit bit; error clear zeroes only the inhibit bit. Clears take precedence over writes and strobes.
- R10: None of the clear inputs changes the word count.
- R11: The synchronous reset zeroes the word count, the address, the extension field and the inhibit bit.
- R12: An accepted write to the address or the extension field in the same cycle as a strobe takes precedence, and the address is not stepped in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 count, 1 address, 2 extension, 3 inhibit |
| wr_be | input | 2 | Byte lane enables |
| wr_data | input | 16 | Write data |
| ready | input | 1 | Channel idle; gates extension and inhibit writes |
| reverse | input | 1 | 1 = address counts down |
| xfer_strobe | input | 1 | One pulse per 36-bit word moved |
| bridge_clr | input | 1 | Bridge-wide clear |
| ctrl_clr | input | 1 | Controller clear |
| err_clr | input | 1 | Error clear |
| word_count | output | 16 | Current word count |
| bus_addr | output | 18 | Current address, bits 17:16 from the extension field |
| addr_inhibit | output | 1 | Current inhibit bit |
| count_zero | output | 1 | Word count equals zero |

## Verification
The bench builds the block with its default widths: a 16-bit data word and a 2-bit extension, so the address spans 18 bits. At these widths the carry out of bit 15 into the extension field, and the full wrap at both ends of the 18-bit space, can be reached with a single register load and one or two strobes. The same holds for the 16-bit count wrapping through zero.

// File: rtl/dmactr_pkg.sv
package dmactr_pkg;

    // Amount both counters move per 36-bit word transferred
    localparam int WORD_STEP = 2;

    typedef enum logic [1:0] {
        RSEL_COUNT = 2'd0,
        RSEL_ADDR  = 2'd1,
        RSEL_EXT   = 2'd2,
        RSEL_INH   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic bridge;
        logic ctrl;
        logic err;
    } clr_req_t;

    typedef struct packed {
        logic cnt;
        logic addr;
        logic ext;
        logic inh;
    } wr_hit_t;

    function automatic logic clears_address(input clr_req_t c);
        return c.bridge | c.ctrl;
    endfunction

endpackage

// File: rtl/dmactr_lane_merge.sv
module dmactr_lane_merge #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]   cur,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   merged
);
    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : cur[g*8 +: 8];
    end
endmodule

// File: rtl/dmactr_wcount.sv
module dmactr_wcount
    import dmactr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                step,
    output logic [DATA_W-1:0]   count,
    output logic                zero
);
    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(WORD_STEP);

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] merged;

    dmactr_lane_merge #(.DATA_W(DATA_W)) u_merge (
        .cur    (cnt_q),
        .wdata  (wdata),
        .be     (be),
        .merged (merged)
    );

    // Clears do not reach this register; only the reset does.
    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (wr)   cnt_q <= merged;
        else if (step) cnt_q <= cnt_q + STEP_V;
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);
endmodule

// File: rtl/dmactr_baddr.sv
module dmactr_baddr
    import dmactr_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int EXT_W   = 2,
    parameter int EXT_LSB = 8,
    parameter int INH_BIT = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ready,
    input  logic                      reverse,
    input  logic                      step,
    input  logic                      wr_addr,
    input  logic                      wr_ext,
    input  logic                      wr_inh,
    input  logic [DATA_W/8-1:0]       be,
    input  logic [DATA_W-1:0]         wdata,
    input  clr_req_t                  clr,
    output logic [DATA_W+EXT_W-1:0]   addr_full,
    output logic                      inhibit
);
    localparam int AW       = DATA_W + EXT_W;
    localparam int EXT_LANE = EXT_LSB / 8;
    localparam int INH_LANE = INH_BIT / 8;
    localparam logic [AW-1:0]     STEP_A  = AW'(WORD_STEP);
    localparam logic [DATA_W-1:0] BIT0_MK = DATA_W'(1);

    logic [DATA_W-1:0] lo_q;
    logic [EXT_W-1:0]  ext_q;
    logic              inh_q;
    logic [DATA_W-1:0] merged;
    logic [AW-1:0]     cur_full;
    logic [AW-1:0]     stepped;
    logic              ext_take;
    logic              inh_take;
    logic              hard;

    dmactr_lane_merge #(.DATA_W(DATA_W)) u_merge (
        .cur    (lo_q),
        .wdata  (wdata),
        .be     (be),
        .merged (merged)
    );

    assign hard     = rst | clears_address(clr);
    assign ext_take = wr_ext & ready & be[EXT_LANE];
    assign inh_take = wr_inh & ready & be[INH_LANE];
    assign cur_full = {ext_q, lo_q};
    assign stepped  = reverse ? (cur_full - STEP_A) : (cur_full + STEP_A);

    always_ff @(posedge clk) begin
        if (hard) begin
            lo_q  <= '0;
            ext_q <= '0;
        end else if (wr_addr || ext_take) begin
            if (wr_addr)  lo_q  <= merged & ~BIT0_MK;
            if (ext_take) ext_q <= wdata[EXT_LSB +: EXT_W];
        end else if (step && !inh_q) begin
            {ext_q, lo_q} <= stepped;
        end
    end

    always_ff @(posedge clk) begin
        if (hard || clr.err) inh_q <= 1'b0;
        else if (inh_take)   inh_q <= wdata[INH_BIT];
    end

    assign addr_full = cur_full;
    assign inhibit   = inh_q;
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
    import dmactr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int EXT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [DATA_W/8-1:0]     wr_be,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    ready,
    input  logic                    reverse,
    input  logic                    xfer_strobe,
    input  logic                    bridge_clr,
    input  logic                    ctrl_clr,
    input  logic                    err_clr,
    output logic [DATA_W-1:0]       word_count,
    output logic [DATA_W+EXT_W-1:0] bus_addr,
    output logic                    addr_inhibit,
    output logic                    count_zero
);
    reg_sel_e sel;
    wr_hit_t  hit;
    clr_req_t clr;
    logic     any_lane;

    assign sel      = reg_sel_e'(wr_sel);
    assign any_lane = |wr_be;

    always_comb begin
        hit      = '0;
        hit.cnt  = wr_en && any_lane && (sel == RSEL_COUNT);
        hit.addr = wr_en && any_lane && (sel == RSEL_ADDR);
        hit.ext  = wr_en && (sel == RSEL_EXT);
        hit.inh  = wr_en && (sel == RSEL_INH);
    end

    assign clr = '{bridge: bridge_clr, ctrl: ctrl_clr, err: err_clr};

    dmactr_wcount #(.DATA_W(DATA_W)) u_wcount (
        .clk   (clk),
        .rst   (rst),
        .wr    (hit.cnt),
        .be    (wr_be),
        .wdata (wr_data),
        .step  (xfer_strobe),
        .count (word_count),
        .zero  (count_zero)
    );

    dmactr_baddr #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_baddr (
        .clk       (clk),
        .rst       (rst),
        .ready     (ready),
        .reverse   (reverse),
        .step      (xfer_strobe),
        .wr_addr   (hit.addr),
        .wr_ext    (hit.ext),
        .wr_inh    (hit.inh),
        .be        (wr_be),
        .wdata     (wr_data),
        .clr       (clr),
        .addr_full (bus_addr),
        .inhibit   (addr_inhibit)
    );
endmodule

// File: rtl/dma_xfer_counter_chk.sv
module dma_xfer_counter_chk #(
    parameter int DATA_W = 16,
    parameter int EXT_W  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [1:0]              wr_sel,
    input logic [DATA_W/8-1:0]     wr_be,
    input logic [DATA_W-1:0]       wr_data,
    input logic                    ready,
    input logic                    reverse,
    input logic                    xfer_strobe,
    input logic                    bridge_clr,
    input logic                    ctrl_clr,
    input logic                    err_clr,
    input logic [DATA_W-1:0]       word_count,
    input logic [DATA_W+EXT_W-1:0] bus_addr,
    input logic                    addr_inhibit,
    input logic                    count_zero
);
    localparam int AW = DATA_W + EXT_W;
    localparam logic [DATA_W-1:0] CSTEP = DATA_W'(2);
    localparam logic [AW-1:0]     ASTEP = AW'(2);

    logic cnt_wr, addr_wr, hard;
    assign cnt_wr  = wr_en && (wr_sel == 2'd0) && (|wr_be);
    assign addr_wr = wr_en && (|wr_be) &&
                     ((wr_sel == 2'd1) || ((wr_sel == 2'd2) && ready && wr_be[1]));
    assign hard    = bridge_clr || ctrl_clr;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (xfer_strobe && !cnt_wr) |=> (word_count == $past(word_count) + CSTEP)); // R2

    AST_ADDR_FWD: assert property (@(posedge clk) disable iff (rst)
        (xfer_strobe && !addr_inhibit && !reverse && !addr_wr && !hard)
        |=> (bus_addr == $past(bus_addr) + ASTEP)); // R5

    AST_ADDR_REV: assert property (@(posedge clk) disable iff (rst)
        (xfer_strobe && !addr_inhibit && reverse && !addr_wr && !hard)
        |=> (bus_addr == $past(bus_addr) - ASTEP)); // R6

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (xfer_strobe && addr_inhibit && !addr_wr && !hard) |=> $stable(bus_addr)); // R7

    AST_EXT_LOCK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == 2'd2) && !ready && !xfer_strobe && !hard)
        |=> $stable(bus_addr)); // R8

    AST_HARD_CLR: assert property (@(posedge clk) disable iff (rst)
        hard |=> ((bus_addr == '0) && !addr_inhibit)); // R9

    AST_CNT_NOCLR: assert property (@(posedge clk) disable iff (rst)
        ((hard || err_clr) && !xfer_strobe && !cnt_wr) |=> $stable(word_count)); // R10

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (xfer_strobe && !cnt_wr && (word_count == ~CSTEP + DATA_W'(1))) |=> count_zero); // R3
endmodule

bind dma_xfer_counter dma_xfer_counter_chk #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_chk (.*);

// File: tb/test_dma_xfer_counter.sv
`timescale 1ns/1ps
module test_dma_xfer_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = '0;
    logic        ready = 1'b1;
    logic        reverse = 1'b0;
    logic        xfer_strobe = 1'b0;
    logic        bridge_clr = 1'b0;
    logic        ctrl_clr = 1'b0;
    logic        err_clr = 1'b0;
    logic [15:0] word_count;
    logic [17:0] bus_addr;
    logic        addr_inhibit;
    logic        count_zero;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma_xfer_counter i_dma_xfer_counter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .ready(ready), .reverse(reverse),
        .xfer_strobe(xfer_strobe), .bridge_clr(bridge_clr), .ctrl_clr(ctrl_clr),
        .err_clr(err_clr), .word_count(word_count), .bus_addr(bus_addr),
        .addr_inhibit(addr_inhibit), .count_zero(count_zero)
    );

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // inputs change at the falling edge; results read one falling edge later
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; xfer_strobe = 1'b0;
        bridge_clr = 1'b0; ctrl_clr = 1'b0; err_clr = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [1:0] be, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_be = be; wr_data = d;
        tick();
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            xfer_strobe = 1'b1;
            tick();
        end
    endtask

    task automatic t_reset();
        check("R11 count after reset", 18'(word_count), 18'h0);
        check("R11 addr after reset", bus_addr, 18'h0);
        check("R11 inhibit after reset", 18'(addr_inhibit), 18'h0);
        check("R3 zero after reset", 18'(count_zero), 18'h1);
        wr(2'd0, 2'b11, 16'h1234);
        wr(2'd1, 2'b11, 16'h5678);
        wr(2'd2, 2'b10, 16'h0100);
        rst = 1'b1; tick(); rst = 1'b0;
        check("R11 count cleared by reset", 18'(word_count), 18'h0);
        check("R11 addr cleared by reset", bus_addr, 18'h0);
    endtask

    task automatic t_count_lanes();
        wr(2'd0, 2'b11, 16'hABCD);
        check("R1 full count write", 18'(word_count), 18'h0ABCD);
        wr(2'd0, 2'b01, 16'hFF12);
        check("R1 low lane count write", 18'(word_count), 18'h0AB12);
        ready = 1'b0;
        wr(2'd0, 2'b10, 16'h3499);
        ready = 1'b1;
        check("R1 high lane count write", 18'(word_count), 18'h03412);
    endtask

    task automatic t_count_step();
        wr(2'd0, 2'b11, 16'hFFF8);
        check("R3 zero low when loaded", 18'(count_zero), 18'h0);
        strobe(3);
        check("R2 count after 3 strobes", 18'(word_count), 18'h0FFFE);
        check("R3 zero still low", 18'(count_zero), 18'h0);
        strobe(1);
        check("R2 count reaches 0", 18'(word_count), 18'h0);
        check("R3 zero after 4 strobes", 18'(count_zero), 18'h1);
        strobe(1);
        check("R2 count wraps past 0", 18'(word_count), 18'h2);
        xfer_strobe = 1'b1;
        wr(2'd0, 2'b11, 16'h0100);
        check("R2 write beats strobe", 18'(word_count), 18'h0100);
    endtask

    task automatic t_addr_lanes();
        wr(2'd1, 2'b11, 16'h1235);
        check("R4 addr write bit0 dropped", bus_addr, 18'h01234);
        wr(2'd1, 2'b01, 16'h00FF);
        check("R4 low lane addr write", bus_addr, 18'h012FE);
        wr(2'd1, 2'b10, 16'hAB11);
        check("R4 high lane addr write", bus_addr, 18'h0ABFE);
    endtask

    task automatic t_forward();
        reverse = 1'b0;
        wr(2'd2, 2'b10, 16'h0000);
        wr(2'd1, 2'b11, 16'hFFFE);
        strobe(1);
        check("R5 carry into extension", bus_addr, 18'h10000);
        wr(2'd2, 2'b10, 16'h0300);
        wr(2'd1, 2'b11, 16'hFFFC);
        strobe(1);
        check("R5 forward step", bus_addr, 18'h3FFFE);
        strobe(1);
        check("R5 forward wrap", bus_addr, 18'h00000);
    endtask

    task automatic t_reverse();
        reverse = 1'b1;
        wr(2'd2, 2'b10, 16'h0100);
        wr(2'd1, 2'b11, 16'h0000);
        strobe(1);
        check("R6 borrow from extension", bus_addr, 18'h0FFFE);
        wr(2'd2, 2'b10, 16'h0000);
        wr(2'd1, 2'b11, 16'h0000);
        strobe(1);
        check("R6 reverse wrap", bus_addr, 18'h3FFFE);
        reverse = 1'b0;
    endtask

    task automatic t_inhibit();
        wr(2'd1, 2'b11, 16'h4000);
        wr(2'd0, 2'b11, 16'h0000);
        wr(2'd3, 2'b01, 16'h0008);
        check("R7 inhibit set", 18'(addr_inhibit), 18'h1);
        strobe(2);
        check("R7 address frozen", bus_addr, 18'h34000);
        check("R7 count still steps", 18'(word_count), 18'h4);
        wr(2'd3, 2'b01, 16'h0000);
    endtask

    task automatic t_ready_gate();
        wr(2'd2, 2'b10, 16'h0000);
        wr(2'd1, 2'b11, 16'h0010);
        ready = 1'b0;
        wr(2'd2, 2'b10, 16'h0200);
        check("R8 extension write ignored", bus_addr, 18'h00010);
        ready = 1'b1;
        wr(2'd3, 2'b01, 16'h0008);
        ready = 1'b0;
        wr(2'd3, 2'b01, 16'h0000);
        check("R8 inhibit write ignored", 18'(addr_inhibit), 18'h1);
        ready = 1'b1;
        wr(2'd3, 2'b01, 16'h0000);
        wr(2'd2, 2'b10, 16'h0200);
        check("R8 extension write accepted", bus_addr, 18'h20010);
    endtask

    task automatic t_clears();
        wr(2'd0, 2'b11, 16'h1234);
        wr(2'd1, 2'b11, 16'hABCC);
        wr(2'd3, 2'b01, 16'h0008);
        err_clr = 1'b1; tick();
        check("R9 error clear drops inhibit", 18'(addr_inhibit), 18'h0);
        check("R9 error clear keeps address", bus_addr, 18'h2ABCC);
        wr(2'd3, 2'b01, 16'h0008);
        bridge_clr = 1'b1; tick();
        check("R9 bridge clear address", bus_addr, 18'h0);
        check("R9 bridge clear inhibit", 18'(addr_inhibit), 18'h0);
        check("R10 bridge clear keeps count", 18'(word_count), 18'h1234);
        wr(2'd1, 2'b11, 16'h0F00);
        ctrl_clr = 1'b1; xfer_strobe = 1'b1;
        wr(2'd1, 2'b11, 16'h5550);
        check("R9 controller clear beats write", bus_addr, 18'h0);
        check("R10 count steps through clear", 18'(word_count), 18'h1236);
    endtask

    task automatic t_precedence();
        wr(2'd1, 2'b11, 16'h0100);
        xfer_strobe = 1'b1;
        wr(2'd1, 2'b11, 16'h0200);
        check("R12 address write beats strobe", bus_addr, 18'h00200);
        xfer_strobe = 1'b1;
        wr(2'd2, 2'b10, 16'h0100);
        check("R12 extension write beats strobe", bus_addr, 18'h10200);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        t_reset();
        t_count_lanes();
        t_count_step();
        t_addr_lanes();
        t_forward();
        t_reverse();
        t_inhibit();
        t_ready_gate();
        t_clears();
        t_precedence();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule